// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block runs clause-22 management transactions from a host register toward an external PHY over a two-wire management port. The host first sets a divider select and a port-enable bit. It then writes one 32-bit management word that holds the start code, the operation, the PHY address, the register address and the write data. The write launches a frame, and the block reports busy by holding its idle flag low.

The block derives MDC from the system clock using one of four fixed ratios. It sends a preamble of ones followed by the management word, most significant bit first. It changes MDIO only on falling MDC edges and samples the PHY on rising edges. On reads it releases the line from the turnaround onward. When a read completes, the sixteen bits from the PHY replace the low half of the management word. The idle flag then returns high, and the host polls it.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: Registers are selected by host_addr: 0 holds control (bit 0 is port enable), 1 holds config (bits 1:0 are divider select), 2 holds status (bit 0 is idle, read-only) and 3 holds the management word. After reset, control is 0, the word is 0, idle reads 1, and mdc and mdio_oe are low.
- R2: Divider select values 0, 1, 2 and 3 give MDC periods of 8, 16, 32 and 64 system clocks, half high and half low. The select is latched when a frame starts.
- R3: After reset, the divider select is 3 when SYS_CLK_HZ is above 80 MHz, 2 above 40 MHz, 1 above 20 MHz, and 0 otherwise.
- R4: A word is valid when bits 31:30 are 01 and bits 29:28 are 10 (read) or 01 (write). Writing a valid word while the port is enabled and idle starts a frame, and idle reads 0 on the next cycle.
- R5: A frame is 32 ones followed by word bits 31 down to 0, one bit per MDC period. On writes, bits 17:16 (turnaround) are always sent as 10. Word bits 27:23 and 22:18 are the PHY and register addresses.
- R6: While a frame is running, mdio_out changes only in the cycle where mdc falls.
- R7: A read drives mdio_oe high for frame bits 0 to 45 and low for bits 46 to 63, which cover the turnaround and the data. A write drives mdio_oe high for all 64 bits.
- R8: mdio_in is sampled on the rising edge of mdc for bits 48 to 63, MSB first. A completed read replaces word bits 15:0 with those bits and keeps bits 31:16. A completed write leaves the word unchanged.
- R9: After 64 MDC periods, idle returns high with mdc and mdio_oe low.
- R10: A write to the word while a frame runs is ignored. Both the frame and the stored word are unaffected.
- R11: With the port disabled, a word write is stored but starts no frame. Clearing the enable during a frame aborts it: on the next cycle, idle is high, mdc and mdio_oe are low, and the word is unchanged.
- R12: A word with an invalid start code or operation is stored and starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 2 | Register select |
| host_wr_en | input | 1 | Register write strobe |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data, combinational |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_in | input | 1 | Management data in |

## Verification
The faults that matter most here are a wrong bit counter or a wrong divider count. A wrong bit counter shows up within one MDC period as a shifted frame, a misplaced release of mdio_oe, or a frame that is not exactly 64 rising edges long. A wrong divider count shows up as a wrong time between the first two MDC rises. A wrong sampling point or edge appears only when the frame ends, as a wrong low half in the word read back. The busy, disabled and invalid-code cases are visible on the next cycle through the idle flag and through MDC staying quiet.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int PREAMBLE_BITS = 32;
  localparam int FRAME_W       = 32;
  localparam int DATA_W        = 16;
  localparam int TOTAL_BITS    = PREAMBLE_BITS + FRAME_W;
  localparam int IDX_W         = $clog2(TOTAL_BITS);
  localparam int FRAME_PW      = $clog2(FRAME_W);
  localparam int TA_POS        = PREAMBLE_BITS + 14;
  localparam int DATA_POS      = PREAMBLE_BITS + 16;
  localparam int MIN_HALF      = 4;
  localparam int DIV_SEL_W     = 2;
  localparam int DIV_CNT_W     = $clog2(MIN_HALF << 3) + 1;
  localparam int REG_AW        = 2;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL = 2'd0,
    RA_CFG  = 2'd1,
    RA_STAT = 2'd2,
    RA_WORD = 2'd3
  } reg_addr_e;

  localparam logic [1:0] ST_CL22  = 2'b01;
  localparam logic [1:0] OP_RD    = 2'b10;
  localparam logic [1:0] OP_WR    = 2'b01;
  localparam logic [1:0] TA_DRIVE = 2'b10;

  // Divider select ladder by system clock frequency
  function automatic logic [DIV_SEL_W-1:0] pick_div_sel(input int unsigned hz);
    if (hz > 32'd80_000_000) return 2'd3;
    else if (hz > 32'd40_000_000) return 2'd2;
    else if (hz > 32'd20_000_000) return 2'd1;
    else return 2'd0;
  endfunction

  // System clocks per MDC half period
  function automatic logic [DIV_CNT_W-1:0] half_period(input logic [DIV_SEL_W-1:0] sel);
    return DIV_CNT_W'(MIN_HALF) << sel;
  endfunction

  function automatic logic word_valid(input logic [FRAME_W-1:0] w);
    return (w[31:30] == ST_CL22) && ((w[29:28] == OP_RD) || (w[29:28] == OP_WR));
  endfunction

  function automatic logic [FRAME_W-1:0] build_frame(input logic [FRAME_W-1:0] w,
                                                     input logic rd);
    if (rd) return w;
    return {w[31:18], TA_DRIVE, w[15:0]};
  endfunction

  function automatic logic frame_bit(input logic [FRAME_W-1:0] tx,
                                     input logic [IDX_W-1:0] idx);
    logic [IDX_W-1:0] p;
    if (idx < IDX_W'(PREAMBLE_BITS)) return 1'b1;
    p = IDX_W'(TOTAL_BITS - 1) - idx;
    return tx[p[FRAME_PW-1:0]];
  endfunction

  function automatic logic drive_bit(input logic rd, input logic [IDX_W-1:0] idx);
    return !(rd && (idx >= IDX_W'(TA_POS)));
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
  import mdio_mgmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic [DIV_SEL_W-1:0] sel,
  output logic                 mdc,
  output logic                 rise_evt,
  output logic                 fall_evt
);
  logic [DIV_CNT_W-1:0] cnt;
  logic                 tick;

  assign tick     = run && (cnt == half_period(sel) - DIV_CNT_W'(1));
  assign rise_evt = tick && !mdc;
  assign fall_evt = tick && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + DIV_CNT_W'(1);
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               abort,
  input  logic [FRAME_W-1:0] word_in,
  input  logic               rd_in,
  input  logic               rise_evt,
  input  logic               fall_evt,
  input  logic               mdio_in,
  output logic               busy,
  output logic               mdio_out,
  output logic               mdio_oe,
  output logic [IDX_W-1:0]   bit_idx,
  output logic               rd_q,
  output logic               frame_end,
  output logic [DATA_W-1:0]  rd_data
);
  logic [FRAME_W-1:0] tx_q;
  logic               last_bit;
  logic [IDX_W-1:0]   nxt_idx;
  logic               sample_now;

  assign last_bit   = (bit_idx == IDX_W'(TOTAL_BITS - 1));
  assign nxt_idx    = bit_idx + IDX_W'(1);
  assign frame_end  = busy && !abort && fall_evt && last_bit;
  assign sample_now = busy && !abort && rise_evt && rd_q && (bit_idx >= IDX_W'(DATA_POS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      mdio_out <= 1'b0;
      mdio_oe  <= 1'b0;
      bit_idx  <= '0;
      rd_q     <= 1'b0;
      tx_q     <= '0;
    end else if (abort) begin
      busy     <= 1'b0;
      mdio_out <= 1'b0;
      mdio_oe  <= 1'b0;
    end else if (start && !busy) begin
      busy     <= 1'b1;
      bit_idx  <= '0;
      rd_q     <= rd_in;
      tx_q     <= build_frame(word_in, rd_in);
      mdio_out <= 1'b1;
      mdio_oe  <= 1'b1;
    end else if (busy && fall_evt) begin
      if (last_bit) begin
        busy     <= 1'b0;
        mdio_out <= 1'b0;
        mdio_oe  <= 1'b0;
      end else begin
        bit_idx  <= nxt_idx;
        mdio_out <= frame_bit(tx_q, nxt_idx) && drive_bit(rd_q, nxt_idx);
        mdio_oe  <= drive_bit(rd_q, nxt_idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else if (start && !busy && !abort) rd_data <= '0;
    else if (sample_now) rd_data <= {rd_data[DATA_W-2:0], mdio_in};
  end
endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
  import mdio_mgmt_pkg::*;
#(
  parameter logic [DIV_SEL_W-1:0] DEFAULT_SEL = 2'd0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [REG_AW-1:0]    host_addr,
  input  logic                 host_wr_en,
  input  logic [FRAME_W-1:0]   host_wdata,
  output logic [FRAME_W-1:0]   host_rdata,
  input  logic                 busy,
  input  logic                 frame_end,
  input  logic                 rd_done,
  input  logic [DATA_W-1:0]    rd_data,
  output logic                 ctrl_en,
  output logic [DIV_SEL_W-1:0] div_sel,
  output logic                 start_req,
  output logic                 start_rd,
  output logic [FRAME_W-1:0]   word_q
);
  logic word_wr;

  assign word_wr   = host_wr_en && (host_addr == RA_WORD) && !busy;
  assign start_req = word_wr && ctrl_en && word_valid(host_wdata);
  assign start_rd  = (host_wdata[29:28] == OP_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en <= 1'b0;
      div_sel <= DEFAULT_SEL;
      word_q  <= '0;
    end else begin
      if (host_wr_en && host_addr == RA_CTRL) ctrl_en <= host_wdata[0];
      if (host_wr_en && host_addr == RA_CFG)  div_sel <= host_wdata[DIV_SEL_W-1:0];
      if (word_wr)
        word_q <= host_wdata;
      else if (frame_end && rd_done)
        word_q[DATA_W-1:0] <= rd_data;
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      RA_CTRL: host_rdata[0] = ctrl_en;
      RA_CFG:  host_rdata[DIV_SEL_W-1:0] = div_sel;
      RA_STAT: host_rdata[0] = !busy;
      default: host_rdata = word_q;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ = 50_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        host_addr,
  input  logic              host_wr_en,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              mdc,
  output logic              mdio_out,
  output logic              mdio_oe,
  input  logic              mdio_in
);
  localparam logic [DIV_SEL_W-1:0] DEFAULT_SEL = pick_div_sel(SYS_CLK_HZ);

  logic                 ctrl_en;
  logic [DIV_SEL_W-1:0] div_sel;
  logic [DIV_SEL_W-1:0] run_sel;
  logic                 start_req;
  logic                 start_rd;
  logic [FRAME_W-1:0]   word_q;
  logic                 busy;
  logic                 rise_evt;
  logic                 fall_evt;
  logic [IDX_W-1:0]     bit_idx;
  logic                 rd_active;
  logic                 frame_end;
  logic [DATA_W-1:0]    rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_sel <= DEFAULT_SEL;
    else if (start_req) run_sel <= div_sel;
  end

  mdio_host_regs #(.DEFAULT_SEL(DEFAULT_SEL)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_addr(host_addr), .host_wr_en(host_wr_en),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .busy(busy), .frame_end(frame_end), .rd_done(rd_active), .rd_data(rd_data),
    .ctrl_en(ctrl_en), .div_sel(div_sel),
    .start_req(start_req), .start_rd(start_rd), .word_q(word_q)
  );

  mdio_mdc_gen u_mdc (
    .clk(clk), .rst_n(rst_n),
    .run(busy && ctrl_en), .sel(run_sel),
    .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n),
    .start(start_req), .abort(!ctrl_en),
    .word_in(host_wdata), .rd_in(start_rd),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .mdio_in(mdio_in),
    .busy(busy), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
    .bit_idx(bit_idx), .rd_q(rd_active),
    .frame_end(frame_end), .rd_data(rd_data)
  );
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk
  import mdio_mgmt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             mdc,
  input logic             mdio_out,
  input logic             mdio_oe,
  input logic             busy,
  input logic             rise_evt,
  input logic             fall_evt,
  input logic             ctrl_en,
  input logic             rd_active,
  input logic [IDX_W-1:0] bit_idx
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  // R2
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_evt, fall_evt}));

  // R6
  out_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (mdio_out != $past(mdio_out))) |-> $past(fall_evt));

  // R7
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_active && bit_idx >= IDX_W'(TA_POS)) |-> !mdio_oe);

  // R7
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_active) |-> mdio_oe);

  // R9
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctrl_en && fall_evt && bit_idx == IDX_W'(TOTAL_BITS - 1)) |=> !busy);

  // R11
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> !busy);
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
  .busy(busy), .rise_evt(rise_evt), .fall_evt(fall_evt), .ctrl_en(ctrl_en),
  .rd_active(rd_active), .bit_idx(bit_idx)
);

// File: tb/mdio_mgmt_ctrl_tb.sv
module mdio_mgmt_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int unsigned SYS_HZ = 50_000_000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic        host_wr_en = 1'b0;
  logic [31:0] host_wdata = 32'd0;
  wire  [31:0] host_rdata;
  wire         mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b0;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_mgmt_ctrl #(.SYS_CLK_HZ(SYS_HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr_en(host_wr_en),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  // PHY-side capture model
  int          cap_cnt = 0;
  logic        cap_out [64];
  logic        cap_oe  [64];
  logic [15:0] phy_data = 16'h0;
  int          cyc = 0;
  int          rise_prev = 0;
  int          period_meas = 0;

  always @(posedge clk) cyc++;

  always @(posedge mdc) begin
    if (cap_cnt < 64) begin
      cap_out[cap_cnt] = mdio_out;
      cap_oe[cap_cnt]  = mdio_oe;
    end
    if (cap_cnt == 1) period_meas = cyc - rise_prev;
    rise_prev = cyc;
    cap_cnt++;
    if (cap_cnt >= 48 && cap_cnt < 64) mdio_in = phy_data[63 - cap_cnt];
    else mdio_in = 1'b0;
  end

  // R6 monitor
  bit   mon_en = 1'b0;
  int   r6_viol = 0;
  logic prev_out = 1'b0;
  logic prev_mdc = 1'b0;
  always @(negedge clk) begin
    if (mon_en && cap_cnt > 0 && mdio_out !== prev_out && !(prev_mdc && !mdc)) r6_viol++;
    prev_out = mdio_out;
    prev_mdc = mdc;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr_en = 1'b1;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [31:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      read_reg(2'd2, s);
      if (s[0]) break;
    end
  endtask

  function automatic logic [1:0] exp_sel(input int unsigned hz);
    logic [1:0] r = 2'd0;
    if (hz > 20_000_000) r = 2'd1;
    if (hz > 40_000_000) r = 2'd2;
    if (hz > 80_000_000) r = 2'd3;
    return r;
  endfunction

  function automatic logic exp_bit(input logic [31:0] w, input int i);
    logic [31:0] f;
    if (i < 32) return 1'b1;
    f = (w[29:28] == 2'b10) ? w : {w[31:18], 2'b10, w[15:0]};
    return f[63 - i];
  endfunction

  function automatic logic exp_oe(input logic [31:0] w, input int i);
    return !((w[29:28] == 2'b10) && i >= 46);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    read_reg(2'd0, d); chk(d == 0, "R1 ctrl reset", d, 0);
    read_reg(2'd2, d); chk(d == 1, "R1 idle reset", d, 1);
    read_reg(2'd3, d); chk(d == 0, "R1 word reset", d, 0);
    chk(!mdc && !mdio_oe, "R1 pins reset", {mdc, mdio_oe}, 0);
    read_reg(2'd1, d); chk(d == 32'(exp_sel(SYS_HZ)), "R3 default divider", d, 32'(exp_sel(SYS_HZ)));
  endtask

  task automatic run_frame(input logic [31:0] w, input logic [1:0] sel, input logic [15:0] pd);
    logic [31:0] d, ew;
    int bad_bits, bad_oe;
    phy_data = pd;
    write_reg(2'd1, 32'(sel));
    write_reg(2'd0, 32'd1);
    cap_cnt = 0; r6_viol = 0; mon_en = 1'b1;
    write_reg(2'd3, w);
    read_reg(2'd2, d); chk(d[0] == 1'b0, "R4 busy after start", d, 0);
    wait_idle();
    mon_en = 1'b0;
    chk(cap_cnt == 64, "R9 mdc rises per frame", cap_cnt, 64);
    chk(!mdc && !mdio_oe, "R9 pins quiet at end", {mdc, mdio_oe}, 0);
    chk(period_meas == (8 << sel), "R2 mdc period", period_meas, 8 << sel);
    bad_bits = 0; bad_oe = 0;
    for (int i = 0; i < 64; i++) begin
      if (cap_oe[i] !== exp_oe(w, i)) bad_oe++;
      if (exp_oe(w, i) && cap_out[i] !== exp_bit(w, i)) bad_bits++;
    end
    chk(bad_bits == 0, "R5 frame bits", bad_bits, 0);
    chk(bad_oe == 0, "R7 output enable pattern", bad_oe, 0);
    chk(r6_viol == 0, "R6 out changes on mdc fall", r6_viol, 0);
    ew = (w[29:28] == 2'b10) ? {w[31:16], pd} : w;
    read_reg(2'd3, d); chk(d == ew, "R8 word after frame", d, ew);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] a, b, d, ew;
    int bad;
    a = {2'b01, 2'b10, 5'd9, 5'd17, 2'b00, 16'h0};
    b = {2'b01, 2'b01, 5'd2, 5'd3, 2'b00, 16'hFFFF};
    phy_data = 16'h3C96;
    write_reg(2'd1, 32'd0); write_reg(2'd0, 32'd1);
    cap_cnt = 0;
    write_reg(2'd3, a);
    repeat (60) @(negedge clk);
    write_reg(2'd3, b);
    wait_idle();
    bad = 0;
    for (int i = 0; i < 46; i++) if (cap_out[i] !== exp_bit(a, i)) bad++;
    chk(bad == 0, "R10 frame kept", bad, 0);
    ew = {a[31:16], 16'h3C96};
    read_reg(2'd3, d); chk(d == ew, "R10 word kept", d, ew);
  endtask

  task automatic t_disabled();
    logic [31:0] w, d;
    w = {2'b01, 2'b01, 5'd1, 5'd1, 2'b00, 16'h1234};
    write_reg(2'd0, 32'd0);
    cap_cnt = 0;
    write_reg(2'd3, w);
    repeat (100) @(negedge clk);
    read_reg(2'd2, d); chk(d == 1 && cap_cnt == 0, "R11 disabled no frame", cap_cnt, 0);
    read_reg(2'd3, d); chk(d == w, "R11 disabled word stored", d, w);
  endtask

  task automatic t_abort();
    logic [31:0] w, d;
    w = {2'b01, 2'b10, 5'd4, 5'd5, 2'b00, 16'hA0A0};
    phy_data = 16'h5555;
    write_reg(2'd1, 32'd0); write_reg(2'd0, 32'd1);
    write_reg(2'd3, w);
    repeat (150) @(negedge clk);
    read_reg(2'd2, d); chk(d == 0, "R11 busy before abort", d, 0);
    write_reg(2'd0, 32'd0);
    @(negedge clk);
    read_reg(2'd2, d); chk(d == 1, "R11 idle after abort", d, 1);
    chk(!mdc && !mdio_oe, "R11 pins quiet after abort", {mdc, mdio_oe}, 0);
    read_reg(2'd3, d); chk(d == w, "R11 word after abort", d, w);
  endtask

  task automatic t_bad_code();
    logic [31:0] w1, w2, d;
    w1 = {2'b00, 2'b10, 5'd1, 5'd2, 2'b00, 16'h0};
    w2 = {2'b01, 2'b11, 5'd1, 5'd2, 2'b00, 16'h0};
    write_reg(2'd0, 32'd1);
    cap_cnt = 0;
    write_reg(2'd3, w1);
    repeat (50) @(negedge clk);
    read_reg(2'd2, d); chk(d == 1 && cap_cnt == 0, "R12 bad start code", cap_cnt, 0);
    read_reg(2'd3, d); chk(d == w1, "R12 word stored", d, w1);
    write_reg(2'd3, w2);
    repeat (50) @(negedge clk);
    read_reg(2'd2, d); chk(d == 1 && cap_cnt == 0, "R12 bad op", cap_cnt, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_frame({2'b01, 2'b01, 5'd3, 5'd4, 2'b00, 16'hBEEF}, 2'd0, 16'h0);
    run_frame({2'b01, 2'b10, 5'd1, 5'd2, 2'b11, 16'h0}, 2'd1, 16'hA5C3);
    run_frame({2'b01, 2'b01, 5'd31, 5'd0, 2'b01, 16'h8001}, 2'd2, 16'h0);
    run_frame({2'b01, 2'b10, 5'd0, 5'd31, 2'b00, 16'hFFFF}, 2'd3, 16'h1234);
    t_busy_ignore();
    t_disabled();
    t_abort();
    t_bad_code();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule